// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of up to 32 general-purpose pins behind a 32-bit, zero-wait-state, APB-style register port. Each pin works as a general input, a general output or an interrupt input. Interrupt inputs detect a level or an edge. A polarity bit selects which sense, and an optional both-edge mode reacts to any transition. Edge events are latched into a status register. The bank drives one interrupt line, which is high while any status bit has its enable bit set.

Pin inputs pass through a synchronizer chain before any use. Output-enable and output data go straight to the pad ring. Software enables pins through a set-only register and disables them through a clear-on-zero register, so it never needs a read-modify-write on the enable vector. Clearing a status bit works the same way: software writes a 1 to it. A read of the input-data word returns the driven value for output pins and the synchronized pad level for all other pins.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, pin_oe and pin_out are 0 and irq is 0.
- R2: pin_oe bit i is 1 exactly when the pin's mode bit is 0 (general I/O) and its direction bit is 1. pin_out equals the output-data register.
- R3: A read of the input-data word returns the output-data bit for general-output pins. For every other pin it returns the pad level, delayed by the two-flop synchronizer.
- R4: For a pin with mode bit 1 and edge bit 0 (level), the status bit equals the synchronized pad level XOR its polarity bit. A clear write has no lasting effect on it.
- R5: For an edge pin with both-edge bit 0, polarity 0 latches a rising transition and polarity 1 latches a falling one. The opposite transition latches nothing.
- R6: For an edge pin with both-edge bit 1, both rising and falling transitions latch the status bit, whatever the polarity.
- R7: Writing 1 to a bit of the clear word clears that latched edge status bit. Writing 0 leaves it unchanged.
- R8: If an edge event and a clear write hit the same bit in the same cycle, the status bit stays set.
- R9: Writing 1 to a bit of the unmask word sets that enable bit. Writing 0 to a bit of the mask word clears that enable bit. Bits written as 1 to the mask word keep their value. The mask word reads back the enable vector.
- R10: irq is 1 exactly when status AND enable is nonzero. A latched status bit with its enable bit at 0 stays readable but does not raise irq.
- R11: Byte offsets (bits [1:0] ignored): mode 0x00, direction 0x04, output data 0x08, input data 0x0C (read-only), status 0x10 (read-only), clear 0x14 (write-only, reads 0), mask 0x18, unmask 0x1C (write-only, reads 0), polarity 0x20, edge select 0x24, both-edge 0x4C. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bank selected for this transfer |
| bus_en | input | 1 | Access phase; a write commits on the edge where sel, en and write are all 1 |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_sel is 1, else 0 |
| pin_in | input | NPINS | Pad input levels (asynchronous) |
| pin_out | output | NPINS | Pad output data |
| pin_oe | output | NPINS | Pad output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The collision that matters is a detected edge and a software clear on the same pin in the same clock. The bench releases a pin transition two edges before the access phase of a clear write, so that the event and the write commit on the same edge. It then expects the status bit to read 1. A later clear with no event must drop the bit. Enable and disable writes also cross pending status bits, and irq is judged against the status and enable values the bench predicts.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
   localparam int BUS_W = 32;
   localparam int MAX_PINS = 32;
   // word indices (byte offset / 4)
   localparam int W_MODE   = 0;
   localparam int W_DIR    = 1;
   localparam int W_DOUT   = 2;
   localparam int W_DIN    = 3;
   localparam int W_STAT   = 4;
   localparam int W_CLR    = 5;
   localparam int W_MASK   = 6;
   localparam int W_UNMASK = 7;
   localparam int W_POL    = 8;
   localparam int W_EDGE   = 9;
   localparam int W_BOTH   = 19;
   localparam int MIN_ADDR_W = 7;
endpackage

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   logic [N-1:0] chain_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= '0;
               else        chain_q[0] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int N        = 32,
   parameter int ADDR_W   = 8,
   parameter bit HAS_BOTH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_en,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [N-1:0]      din_i,
   input  logic [N-1:0]      stat_i,
   output logic [N-1:0]      mode_o,
   output logic [N-1:0]      dir_o,
   output logic [N-1:0]      dout_o,
   output logic [N-1:0]      pol_o,
   output logic [N-1:0]      edge_o,
   output logic [N-1:0]      both_o,
   output logic [N-1:0]      mask_o,
   output logic [N-1:0]      clr_o
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] widx;
   logic [N-1:0]     wdata_n;
   logic             wr;
   logic             unused_lsb;
   logic [N-1:0]     mode_q, dir_q, dout_q, pol_q, edge_q, both_q, mask_q;
   logic [N-1:0]     rd;

   assign widx       = bus_addr[ADDR_W-1:2];
   assign unused_lsb = ^bus_addr[1:0];
   assign wdata_n    = bus_wdata[N-1:0];
   assign wr         = bus_sel & bus_en & bus_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         dir_q  <= '0;
         dout_q <= '0;
         pol_q  <= '0;
         edge_q <= '0;
         both_q <= '0;
         mask_q <= '0;
      end else if (wr) begin
         case (32'(widx))
            W_MODE:   mode_q <= wdata_n;
            W_DIR:    dir_q  <= wdata_n;
            W_DOUT:   dout_q <= wdata_n;
            W_POL:    pol_q  <= wdata_n;
            W_EDGE:   edge_q <= wdata_n;
            W_BOTH:   both_q <= wdata_n;
            W_MASK:   mask_q <= mask_q & wdata_n;
            W_UNMASK: mask_q <= mask_q | wdata_n;
            default: ;
         endcase
      end
   end

   generate
      if (HAS_BOTH) begin : g_both
         assign both_o = both_q;
      end else begin : g_no_both
         logic unused_both;
         assign unused_both = ^both_q;
         assign both_o = '0;
      end
   endgenerate

   assign mode_o = mode_q;
   assign dir_o  = dir_q;
   assign dout_o = dout_q;
   assign pol_o  = pol_q;
   assign edge_o = edge_q;
   assign mask_o = mask_q;
   assign clr_o  = (wr && 32'(widx) == W_CLR) ? wdata_n : '0;

   always_comb begin
      case (32'(widx))
         W_MODE:  rd = mode_q;
         W_DIR:   rd = dir_q;
         W_DOUT:  rd = dout_q;
         W_DIN:   rd = din_i;
         W_STAT:  rd = stat_i;
         W_MASK:  rd = mask_q;
         W_POL:   rd = pol_q;
         W_EDGE:  rd = edge_q;
         W_BOTH:  rd = both_o;
         default: rd = '0;
      endcase
   end

   assign bus_rdata = bus_sel ? BUS_W'(rd) : '0;
endmodule

// File: rtl/gpio_bank_detect.sv
`timescale 1ns/1ps
module gpio_bank_detect #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   input  logic [N-1:0] mode_i,
   input  logic [N-1:0] edge_i,
   input  logic [N-1:0] pol_i,
   input  logic [N-1:0] both_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o,
   output logic [N-1:0] latch_o,
   output logic [N-1:0] ev_o
);
   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_pin
         logic prev_q, latch_q, rise, fall, armed;

         assign rise  = lvl_i[i] & ~prev_q;
         assign fall  = ~lvl_i[i] & prev_q;
         assign armed = mode_i[i] & edge_i[i];
         assign ev_o[i] = armed & (both_i[i] ? (rise | fall)
                                             : (pol_i[i] ? fall : rise));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q  <= 1'b0;
               latch_q <= 1'b0;
            end else begin
               prev_q  <= lvl_i[i];
               if (!armed) latch_q <= 1'b0;
               else        latch_q <= ev_o[i] | (latch_q & ~clr_i[i]);
            end
         end

         assign latch_o[i] = latch_q;
         assign stat_o[i]  = edge_i[i] ? latch_q
                                       : (mode_i[i] & (lvl_i[i] ^ pol_i[i]));
      end
   endgenerate
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_BOTH    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_en,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   generate
      if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
         $error("NPINS must lie in 1..32");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the both-edge word");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NPINS-1:0] pin_s, din_v, stat_v, latch_v, ev_v, clr_v;
   logic [NPINS-1:0] mode_r, dir_r, dout_r, pol_r, edge_r, both_r, mask_r;
   logic [NPINS-1:0] drive_v;

   gpio_bank_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(pin_s)
   );

   gpio_bank_regs #(.N(NPINS), .ADDR_W(ADDR_W), .HAS_BOTH(HAS_BOTH)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_en(bus_en), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .din_i(din_v), .stat_i(stat_v),
      .mode_o(mode_r), .dir_o(dir_r), .dout_o(dout_r), .pol_o(pol_r),
      .edge_o(edge_r), .both_o(both_r), .mask_o(mask_r), .clr_o(clr_v)
   );

   gpio_bank_detect #(.N(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl_i(pin_s),
      .mode_i(mode_r), .edge_i(edge_r), .pol_i(pol_r), .both_i(both_r),
      .clr_i(clr_v), .stat_o(stat_v), .latch_o(latch_v), .ev_o(ev_v)
   );

   assign drive_v = dir_r & ~mode_r;
   assign pin_oe  = drive_v;
   assign pin_out = dout_r;
   assign din_v   = (drive_v & dout_r) | (~drive_v & pin_s);
   assign irq     = |(stat_v & mask_r);
endmodule

// File: rtl/gpio_bank_checker.sv
`timescale 1ns/1ps
module gpio_bank_checker
   import gpio_bank_pkg::*;
#(
   parameter int N      = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_en,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [N-1:0]      pin_s,
   input logic [N-1:0]      mode_r,
   input logic [N-1:0]      edge_r,
   input logic [N-1:0]      pol_r,
   input logic [N-1:0]      stat_v,
   input logic [N-1:0]      latch_v,
   input logic [N-1:0]      ev_v,
   input logic [N-1:0]      mask_r
);
   logic          wr;
   logic [N-1:0]  clr_w, unmask_w, drop_w, armed;
   logic [ADDR_W-3:0] idx;

   assign idx      = bus_addr[ADDR_W-1:2];
   assign wr       = bus_sel & bus_en & bus_write;
   assign clr_w    = (wr && 32'(idx) == W_CLR)    ? bus_wdata[N-1:0]  : '0;
   assign unmask_w = (wr && 32'(idx) == W_UNMASK) ? bus_wdata[N-1:0]  : '0;
   assign drop_w   = (wr && 32'(idx) == W_MASK)   ? ~bus_wdata[N-1:0] : '0;
   assign armed    = mode_r & edge_r;

   // R4: level pins mirror the synchronized, polarity-adjusted pad
   assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_r & ~edge_r) & (stat_v ^ pin_s ^ pol_r)) == '0);

   // R7: a latched edge bit only falls through a clear write on that bit
   assert_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(latch_v) & ~latch_v & $past(armed) & armed) & ~$past(clr_w)) == '0);

   // R8: an event always lands in the latch, clear or not
   assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ev_v) & $past(armed) & armed & ~latch_v) == '0);

   // R9: enable bits rise only through the unmask word
   assert_unmask_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_r & ~$past(mask_r) & ~$past(unmask_w)) == '0);

   // R9: enable bits fall only through a zero written to the mask word
   assert_mask_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (~mask_r & $past(mask_r) & ~$past(drop_w)) == '0);
endmodule

bind gpio_irq_bank gpio_bank_checker #(.N(NPINS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
   .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .pin_s(pin_s), .mode_r(mode_r), .edge_r(edge_r), .pol_r(pol_r),
   .stat_v(stat_v), .latch_v(latch_v), .ev_v(ev_v), .mask_r(mask_r)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
   localparam int NP = 32;
   localparam logic [7:0] A_MODE = 8'h00, A_DIR = 8'h04, A_DOUT = 8'h08,
      A_DIN = 8'h0C, A_STAT = 8'h10, A_CLR = 8'h14, A_MASK = 8'h18,
      A_UNMASK = 8'h1C, A_POL = 8'h20, A_EDGE = 8'h24, A_BOTH = 8'h4C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_en = 1'b0, bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_en = 1'b0; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_en = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [31:0] exp_din(logic [31:0] m, logic [31:0] d,
                                           logic [31:0] o, logic [31:0] p);
      logic [31:0] drv;
      drv = d & ~m;
      return (drv & o) | (~drv & p);
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, m, d, o, p, pl, en;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 pin_oe", 32'(pin_oe), 0);
      check("R1 pin_out", 32'(pin_out), 0);
      check("R1 irq", 32'(irq), 0);
      foreach (r[k]) begin end
      begin
         logic [7:0] addrs [10] = '{A_MODE, A_DIR, A_DOUT, A_DIN, A_STAT,
                                    A_MASK, A_POL, A_EDGE, A_BOTH, A_UNMASK};
         for (int k = 0; k < 10; k++) begin
            rd(addrs[k], r);
            check($sformatf("R1 reg @%h", addrs[k]), r, 0);
         end
      end

      // R11 both-edge word at 0x4C, clear word reads 0
      wr(A_BOTH, 32'h0000_00A5);
      rd(A_BOTH, r); check("R11 both-edge readback", r, 32'h0000_00A5);
      wr(A_BOTH, 0);
      rd(A_CLR, r); check("R11 clear word reads 0", r, 0);

      // R2/R3 random general I/O
      for (int it = 0; it < 30; it++) begin
         m = $urandom(); d = $urandom(); o = $urandom(); p = $urandom();
         wr(A_MODE, m); wr(A_DIR, d); wr(A_DOUT, o);
         @(negedge clk); pin_in = p;
         settle();
         check("R2 pin_oe", 32'(pin_oe), d & ~m);
         check("R2 pin_out", 32'(pin_out), o);
         rd(A_DIN, r); check("R3 input data", r, exp_din(m, d, o, p));
         check("R10 irq off while disabled", 32'(irq), 0);
      end

      // R4/R10 random level sensing
      wr(A_DIR, 0); wr(A_EDGE, 0); wr(A_MODE, 32'hFFFF_FFFF);
      for (int it = 0; it < 20; it++) begin
         pl = $urandom(); p = $urandom();
         en = (it % 4 == 0) ? 32'h0 : $urandom();
         wr(A_POL, pl); wr(A_MASK, 0); wr(A_UNMASK, en);
         @(negedge clk); pin_in = p;
         settle();
         rd(A_STAT, r); check("R4 level status", r, p ^ pl);
         check("R10 level irq", 32'(irq), 32'(|((p ^ pl) & en)));
         wr(A_CLR, 32'hFFFF_FFFF);
         rd(A_STAT, r); check("R4 clear has no lasting effect", r, p ^ pl);
      end
      wr(A_MASK, 0); wr(A_MODE, 0); wr(A_POL, 0);
      @(negedge clk); pin_in = '0;
      settle();

      // Edge setup: pin0 rising, pin1 falling, pin2 both edges
      wr(A_POL, 32'h2); wr(A_BOTH, 32'h4); wr(A_EDGE, 32'h7); wr(A_MODE, 32'h7);
      wr(A_CLR, 32'h7);
      rd(A_STAT, r); check("R5 status clean after setup", r, 0);

      @(negedge clk); pin_in[0] = 1'b1; settle();
      rd(A_STAT, r); check("R5 rising latched", r, 32'h1);
      @(negedge clk); pin_in[0] = 1'b0; settle();
      rd(A_STAT, r); check("R5 falling ignored on rising pin", r, 32'h1);
      wr(A_CLR, 32'h0);
      rd(A_STAT, r); check("R7 clear with 0 keeps bit", r, 32'h1);
      wr(A_CLR, 32'h1);
      rd(A_STAT, r); check("R7 clear with 1 drops bit", r, 32'h0);

      @(negedge clk); pin_in[1] = 1'b1; settle();
      rd(A_STAT, r); check("R5 rising ignored on falling pin", r, 32'h0);
      @(negedge clk); pin_in[1] = 1'b0; settle();
      rd(A_STAT, r); check("R5 falling latched", r, 32'h2);
      wr(A_CLR, 32'h2);

      @(negedge clk); pin_in[2] = 1'b1; settle();
      rd(A_STAT, r); check("R6 both-edge rise", r, 32'h4);
      wr(A_CLR, 32'h4);
      @(negedge clk); pin_in[2] = 1'b0; settle();
      rd(A_STAT, r); check("R6 both-edge fall", r, 32'h4);
      wr(A_CLR, 32'h4);
      rd(A_STAT, r); check("R6 cleared", r, 32'h0);

      // R9/R10 enable handling with pin0 pending
      @(negedge clk); pin_in[0] = 1'b1; settle();
      check("R10 pending but disabled", 32'(irq), 0);
      wr(A_UNMASK, 32'h1);
      rd(A_MASK, r); check("R9 unmask sets bit", r, 32'h1);
      @(negedge clk); check("R10 irq raised", 32'(irq), 1);
      wr(A_MASK, 32'hFFFF_FFFF);
      rd(A_MASK, r); check("R9 ones keep enable", r, 32'h1);
      wr(A_MASK, 32'hFFFF_FFFE);
      rd(A_MASK, r); check("R9 zero clears enable", r, 32'h0);
      @(negedge clk); check("R10 irq dropped", 32'(irq), 0);
      rd(A_STAT, r); check("R10 status kept while disabled", r, 32'h1);
      wr(A_CLR, 32'h1);
      @(negedge clk); pin_in[0] = 1'b0; settle();

      // R8 event and clear on the same edge
      @(negedge clk); pin_in[0] = 1'b1;
      @(negedge clk);
      bus_sel = 1'b1; bus_en = 1'b0; bus_write = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h1;
      @(negedge clk); bus_en = 1'b1;
      @(negedge clk); bus_sel = 1'b0; bus_en = 1'b0; bus_write = 1'b0;
      rd(A_STAT, r); check("R8 event beats clear", r, 32'h1);
      wr(A_CLR, 32'h1);
      rd(A_STAT, r); check("R8 later clear drops bit", r, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule